// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a processor core that runs in several privilege modes. Software always addresses sixteen 32-bit registers by a 4-bit index. Which physical storage an index reaches depends on the 5-bit mode field of the current status word. The low eight registers and the program-counter slot (index 15) are shared by every mode. A fast-interrupt mode has its own copies of indices 8 to 12. Each exception mode has a private stack pointer (index 13) and link register (index 14).

The file also holds one saved-status word for each exception mode. This word is read and written through a separate port, and the current mode selects which copy is used. There are two combinational read ports and one write port, and writes take effect on the rising clock edge. The program counter is stored like any other shared slot. Advancing it, sequencing exceptions and decoding instructions belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: While the active-low reset is asserted, every register and saved-status copy is cleared, so every read port returns zero.
- R2: Indices 0 to 7 reach one physical set shared by all modes. A value written in any mode is read back unchanged in every other mode.
- R3: Indices 8 to 12 have a private copy used only in fast-interrupt mode (mode 10001). Every other mode uses one common copy, and writes to one copy never change the other.
- R4: Indices 13 and 14 each have a private copy in fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, and these copies are independent of each other.
- R5: System mode (11111) uses the same index 13 and 14 storage as user mode (10000). Any mode encoding not listed in R3, R4 or here behaves as user mode.
- R6: Index 15 is one register shared by all modes.
- R7: Each of the five exception modes of R4 has its own saved-status word. A saved-status write in one of these modes is visible on the saved-status output only while that same mode is active.
- R8: In user, system or any unlisted mode, the saved-status output reads zero and saved-status writes change no stored copy.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R10: The two read ports decode their indices independently and may read any pair of registers in the same cycle, including the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current mode field from the status word |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A value |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B value |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write value |
| sav_wr_en | input | 1 | Saved-status write enable |
| sav_wr_data | input | 32 | Saved-status write value |
| sav_rd_data | output | 32 | Saved-status word of the active mode |

## Verification
Reads have zero latency: both read ports and the saved-status output reflect the current mode and indices in the same cycle. A write becomes visible exactly one rising edge after it is presented. The bench drives inputs just after a falling edge and compares all three outputs a quarter period later, against a keyed reference model. The model updates its contents only at the rising edge, so a same-cycle read-after-write is compared against the old value, and the next cycle against the new one. Mode switches between writes exercise each banked copy, and a long pseudo-random stretch that includes unlisted encodings covers the remaining combinations.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          sav_wr_en,
  input  logic [DW-1:0] sav_wr_data,
  output logic [DW-1:0] sav_rd_data
);
  localparam int NEXC  = 5;
  localparam int NPHYS = 16 + 5 + 2 * NEXC;

  // bank 0: user/system/unlisted, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: return 3'd1;
      5'b10010: return 3'd2;
      5'b10011: return 3'd3;
      5'b10111: return 3'd4;
      5'b11011: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] slot_of(input logic [2:0] b, input logic [3:0] i);
    if (i >= 4'd8 && i <= 4'd12 && b == 3'd1)
      return 5'd16 + {1'b0, i} - 5'd8;
    if ((i == 4'd13 || i == 4'd14) && b != 3'd0)
      return 5'd21 + {1'b0, b - 3'd1, 1'b0} + {4'd0, i[0] ^ 1'b1};
    return {1'b0, i};
  endfunction

  logic [DW-1:0] gpr [NPHYS];
  logic [DW-1:0] spsr [NEXC];

  logic [2:0] bank;
  logic [2:0] sav_sel;
  assign bank    = bank_of(mode);
  assign sav_sel = bank - 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) gpr[k] <= '0;
      for (int k = 0; k < NEXC; k++) spsr[k] <= '0;
    end else begin
      if (wr_en) gpr[slot_of(bank, wr_idx)] <= wr_data;
      if (sav_wr_en && bank != 3'd0) spsr[sav_sel] <= sav_wr_data;
    end
  end

  assign rd_a_data   = gpr[slot_of(bank, rd_a_idx)];
  assign rd_b_data   = gpr[slot_of(bank, rd_b_idx)];
  assign sav_rd_data = (bank == 3'd0) ? '0 : spsr[sav_sel];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    mode,
  input logic [3:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic [3:0]    rd_b_idx,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          sav_wr_en,
  input logic [DW-1:0] sav_wr_data,
  input logic [DW-1:0] sav_rd_data
);
  logic sav_mode;
  assign sav_mode = (mode == 5'b10001) || (mode == 5'b10010) || (mode == 5'b10011) ||
                    (mode == 5'b10111) || (mode == 5'b11011);

  assert_wr_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_b_idx == $past(wr_idx) && mode == $past(mode)) -> rd_b_data == $past(wr_data)));

  assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'd8) |=> (rd_a_idx == $past(wr_idx) -> rd_a_data == $past(wr_data)));

  assert_pc_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> (rd_a_idx == 4'd15 -> rd_a_data == $past(wr_data)));

  assert_sav_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sav_mode |-> sav_rd_data == '0);

  assert_sav_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_wr_en && sav_mode) |=> (mode == $past(mode) -> sav_rd_data == $past(sav_wr_data)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(mode) && $stable(rd_a_idx)) |-> $stable(rd_a_data));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .sav_rd_data(sav_rd_data)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int PERIOD = 10;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = USR;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, sav_rd_data;
  logic        wr_en = 1'b0, sav_wr_en = 1'b0;
  logic [31:0] wr_data = '0, sav_wr_data = '0;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic [31:0] ref_reg [string];
  logic [31:0] ref_sav [string];

  always #(PERIOD/2) clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .sav_rd_data(sav_rd_data)
  );

  function automatic string bank_name(logic [4:0] m);
    case (m)
      FIQ: return "fiq";
      IRQ: return "irq";
      SVC: return "svc";
      ABT: return "abt";
      UND: return "und";
      default: return "usr";
    endcase
  endfunction

  function automatic string reg_key(logic [4:0] m, logic [3:0] i);
    string b = bank_name(m);
    if (i < 8 || i == 15) return $sformatf("g%0d", i);
    if (i <= 12) return (b == "fiq") ? $sformatf("f%0d", i) : $sformatf("g%0d", i);
    return $sformatf("%s%0d", b, i);
  endfunction

  function automatic logic [31:0] ref_read(logic [4:0] m, logic [3:0] i);
    string k = reg_key(m, i);
    return ref_reg.exists(k) ? ref_reg[k] : 32'd0;
  endfunction

  function automatic logic [31:0] ref_sav_read(logic [4:0] m);
    string b = bank_name(m);
    if (b == "usr") return 32'd0;
    return ref_sav.exists(b) ? ref_sav[b] : 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_reg.delete();
      ref_sav.delete();
    end else begin
      if (wr_en) ref_reg[reg_key(mode, wr_idx)] = wr_data;
      if (sav_wr_en && bank_name(mode) != "usr") ref_sav[bank_name(mode)] = sav_wr_data;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (mode %b)", cur_req, what, act, exp, mode);
    end
  endtask

  always @(negedge clk) begin
    #(PERIOD/4);
    cmp("rd_a", rd_a_data, ref_read(mode, rd_a_idx));
    cmp("rd_b", rd_b_data, ref_read(mode, rd_b_idx));
    cmp("sav",  sav_rd_data, ref_sav_read(mode));
  end

  task automatic step(logic [4:0] m, logic [3:0] ra, logic [3:0] rb,
                      logic we, logic [3:0] wi, logic [31:0] wd,
                      logic swe, logic [31:0] swd);
    mode = m; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd;
    sav_wr_en = swe; sav_wr_data = swd;
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] i, logic [31:0] d);
    step(m, i, i, 1'b1, i, d, 1'b0, 32'd0);
  endtask

  task automatic rd(logic [4:0] m, logic [3:0] a, logic [3:0] b);
    step(m, a, b, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] mlist [8] = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b00000};
    logic [31:0] lfsr = 32'h1234_5679;
    @(negedge clk);
    cur_req = "R1";
    step(SVC, 4'd13, 4'd15, 1'b1, 4'd3, 32'hDEAD, 1'b1, 32'hBEEF);
    rd(FIQ, 4'd8, 4'd14);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd(USR, 4'(i), 4'(15 - i));

    cur_req = "R2";
    for (int i = 0; i < 8; i++) wr(USR, 4'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd(mlist[i], 4'(i), 4'(7 - i));

    cur_req = "R3";
    for (int i = 8; i < 13; i++) wr(USR, 4'(i), 32'hC000_0000 + 32'(i));
    for (int i = 8; i < 13; i++) wr(FIQ, 4'(i), 32'hF000_0000 + 32'(i));
    for (int i = 8; i < 13; i++) begin rd(USR, 4'(i), 4'(i)); rd(FIQ, 4'(i), 4'(i)); rd(IRQ, 4'(i), 4'(i)); end

    cur_req = "R4";
    for (int j = 0; j < 6; j++) begin
      wr(mlist[j], 4'd13, 32'h5000_0000 + 32'(j));
      wr(mlist[j], 4'd14, 32'h1400_0000 + 32'(j));
    end
    for (int j = 0; j < 6; j++) rd(mlist[j], 4'd13, 4'd14);

    cur_req = "R5";
    rd(SYS, 4'd13, 4'd14);
    wr(SYS, 4'd13, 32'h5A5A_0013);
    rd(USR, 4'd13, 4'd14);
    wr(5'b00000, 4'd14, 32'h0BAD_0014);
    rd(USR, 4'd14, 4'd13);
    rd(5'b10110, 4'd14, 4'd9);
    rd(SVC, 4'd14, 4'd13);

    cur_req = "R6";
    wr(IRQ, 4'd15, 32'h0000_8000);
    rd(USR, 4'd15, 4'd15);
    rd(FIQ, 4'd15, 4'd0);

    cur_req = "R7";
    for (int j = 1; j < 6; j++) step(mlist[j], 4'd0, 4'd1, 1'b0, 4'd0, 32'd0, 1'b1, 32'h7000_0000 + 32'(j));
    for (int j = 0; j < 8; j++) rd(mlist[j], 4'd0, 4'd1);

    cur_req = "R8";
    step(USR, 4'd0, 4'd0, 1'b0, 4'd0, 32'd0, 1'b1, 32'hFFFF_FFFF);
    step(SYS, 4'd0, 4'd0, 1'b0, 4'd0, 32'd0, 1'b1, 32'hEEEE_EEEE);
    step(5'b00000, 4'd0, 4'd0, 1'b0, 4'd0, 32'd0, 1'b1, 32'hDDDD_DDDD);
    for (int j = 0; j < 8; j++) rd(mlist[j], 4'd2, 4'd3);

    cur_req = "R9";
    wr(SVC, 4'd13, 32'h9999_0001);
    wr(SVC, 4'd13, 32'h9999_0002);
    rd(SVC, 4'd13, 4'd13);
    wr(FIQ, 4'd10, 32'h9999_0003);
    rd(FIQ, 4'd10, 4'd10);

    cur_req = "R10";
    for (int n = 0; n < 600; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      step(mlist[lfsr[31:29]], lfsr[3:0], lfsr[7:4], lfsr[8], lfsr[12:9],
           lfsr ^ 32'h3C3C_A5A5, lfsr[13] & lfsr[14], ~lfsr);
    end

    rd(USR, 4'd0, 4'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule